// File: doc/BRIEF.md
# Five-port mesh packet router

This block is the switching element at one node of a two-dimensional mesh network-on-chip. It has five bidirectional flit channels with valid/ready handshakes. Four of them face the neighbouring nodes: north (toward larger Y), south, east (toward larger X) and west. The fifth connects the processing element attached at this node. Every flit that arrives is held in a per-input FIFO. Each packet leaves on the port that dimension-ordered routing picks: the X offset is corrected first, then the Y offset, and a packet whose destination is this node goes to the local port.

The output choice is worked out once, from the destination coordinates in a packet's head flit. The input keeps that choice until the packet's last flit has gone through. Each output has its own round-robin arbiter. Once an output starts showing a packet's first flit, it stays bound to that input until the closing flit passes. The flits of one packet therefore move through the crossbar back to back and never mix with another packet. Flit width, FIFO depth, coordinate width and this node's own X and Y position are parameters.

Top module: `mesh_router`

## Requirements
- R1: While reset is held and in the first cycle after it, every `out_valid` bit is low and every `in_ready` bit is high.
- R2: Port indices are 0 local, 1 north, 2 south, 3 east, 4 west. A flit's top two bits give its type: 00 body, 01 head, 10 tail, 11 single-flit packet. A head or single flit carries destination X in bits [2*CW-1:CW] and destination Y in bits [CW-1:0]. If destination X is greater than MY_X, the packet leaves on east. If destination X is smaller than MY_X, it leaves on west.
- R3: If destination X equals MY_X, the packet leaves on north when destination Y is greater than MY_Y, on south when it is smaller, and on local when both coordinates match.
- R4: The body and tail flits of a packet leave on the same output as its head. After an output shows a head flit, no flit from any other input appears on that output until the tail has been transferred. An input is shown on at most one output at a time.
- R5: When several inputs compete for a free output, the grant goes to the first requesting input found by scanning upward, with wrap-around, from that output's pointer. The pointer starts at 0. After a packet's closing flit is transferred, the pointer moves to the input just after the one that was served.
- R6: While `out_valid` is high and `out_ready` is low, the output keeps `out_valid` high and keeps `out_flit` unchanged in the next cycle. No flit is lost or duplicated while the output is stalled.
- R7: Each input FIFO accepts up to DEPTH flits. Its `in_ready` is low exactly while it holds DEPTH flits, and it is never popped when empty.
- R8: For every pair of input and output, the flits arrive at the output with unchanged contents and in the order they were accepted. Every accepted flit is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 5 | Per-input flit valid, bit index = port index |
| in_flit | input | 5*FLIT_W | Per-input flit, port p in slice [p*FLIT_W +: FLIT_W] |
| in_ready | output | 5 | Per-input ready, low while the FIFO is full |
| out_valid | output | 5 | Per-output flit valid |
| out_flit | output | 5*FLIT_W | Per-output flit, same slicing as in_flit |
| out_ready | input | 5 | Per-output downstream ready |

## Verification
Some properties are checked by the assertions on every cycle: a stalled output holds its flit, a locked output's owner still routes to it, an input shows on at most one output, a FIFO is never popped when empty, and a head flit on east, west or local agrees with the X and Y rules. Other properties can only be shown by the bench's scenarios. These are the grant order among simultaneous contenders and the pointer wrap after a served input, plus in_ready falling after exactly DEPTH flits. They also cover the intact, in-order delivery of every flit in random five-port traffic with random backpressure, and the absence of interleaving between packets on one output.

// File: rtl/mesh_pkg.sv
package mesh_pkg;
    localparam int NPORT = 5;
    localparam int PW    = 3;

    typedef enum logic [PW-1:0] {
        P_LOCAL = 3'd0,
        P_NORTH = 3'd1,
        P_SOUTH = 3'd2,
        P_EAST  = 3'd3,
        P_WEST  = 3'd4
    } port_e;

    typedef enum logic [1:0] {
        FT_BODY   = 2'b00,
        FT_HEAD   = 2'b01,
        FT_TAIL   = 2'b10,
        FT_SINGLE = 2'b11
    } ftype_e;
endpackage

// File: rtl/mesh_fifo.sv
module mesh_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         pop
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0]   wr;
        logic [AW-1:0]   rd;
        logic [CNTW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t     st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic         push;

    assign in_ready  = (st_q.cnt != CNTW'(DEPTH));
    assign out_valid = (st_q.cnt != '0);
    assign out_data  = mem[st_q.rd];
    assign push      = in_valid && in_ready;

    always_comb begin
        st_d = st_q;
        if (push) st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + AW'(1);
        if (pop)  st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + AW'(1);
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + CNTW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNTW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[st_q.wr] <= in_data;
    end

    // R7: the switch never drains an empty queue
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.cnt != '0));
endmodule

// File: rtl/mesh_xy_route.sv
module mesh_xy_route import mesh_pkg::*; #(
    parameter int CW   = 2,
    parameter int MY_X = 1,
    parameter int MY_Y = 1
) (
    input  logic [CW-1:0] dst_x,
    input  logic [CW-1:0] dst_y,
    output logic [PW-1:0] port
);
    localparam logic [CW-1:0] HX = CW'(MY_X);
    localparam logic [CW-1:0] HY = CW'(MY_Y);

    always_comb begin
        if (dst_x > HX)      port = P_EAST;
        else if (dst_x < HX) port = P_WEST;
        else if (dst_y > HY) port = P_NORTH;
        else if (dst_y < HY) port = P_SOUTH;
        else                 port = P_LOCAL;
    end
endmodule

// File: rtl/mesh_rr_pick.sv
module mesh_rr_pick #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic [IW-1:0] idx,
    output logic          any
);
    int j;

    always_comb begin
        idx = '0;
        any = 1'b0;
        j   = 0;
        for (int k = N - 1; k >= 0; k--) begin
            j = int'(ptr) + k;
            if (j >= N) j = j - N;
            if (req[j]) begin
                idx = IW'(j);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mesh_router.sv
module mesh_router import mesh_pkg::*; #(
    parameter int FLIT_W = 16,
    parameter int DEPTH  = 4,
    parameter int CW     = 2,
    parameter int MY_X   = 1,
    parameter int MY_Y   = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORT-1:0]        in_valid,
    input  logic [NPORT*FLIT_W-1:0] in_flit,
    output logic [NPORT-1:0]        in_ready,
    output logic [NPORT-1:0]        out_valid,
    output logic [NPORT*FLIT_W-1:0] out_flit,
    input  logic [NPORT-1:0]        out_ready
);
    localparam int TL = FLIT_W - 2;
    localparam logic [CW-1:0] HX = CW'(MY_X);
    localparam logic [CW-1:0] HY = CW'(MY_Y);

    typedef struct packed {
        logic [NPORT-1:0]         busy;
        logic [NPORT-1:0][PW-1:0] route;
        logic [NPORT-1:0]         lock;
        logic [NPORT-1:0][PW-1:0] owner;
        logic [NPORT-1:0][PW-1:0] ptr;
    } rt_state_t;

    rt_state_t                    st_d, st_q;
    logic [NPORT-1:0]             fq_valid, pop, pick_any, ov, xfer;
    logic [NPORT-1:0][FLIT_W-1:0] fq_data;
    logic [NPORT-1:0][PW-1:0]     xy_port, cur_port, pick_idx, sel;
    logic [NPORT-1:0][NPORT-1:0]  req;

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        mesh_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (in_valid[i]),
            .in_data  (in_flit[i*FLIT_W +: FLIT_W]),
            .in_ready (in_ready[i]),
            .out_valid(fq_valid[i]),
            .out_data (fq_data[i]),
            .pop      (pop[i])
        );
        mesh_xy_route #(.CW(CW), .MY_X(MY_X), .MY_Y(MY_Y)) u_route (
            .dst_x(fq_data[i][2*CW-1:CW]),
            .dst_y(fq_data[i][CW-1:0]),
            .port (xy_port[i])
        );
        assign cur_port[i] = st_q.busy[i] ? st_q.route[i] : xy_port[i];
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        for (genvar i = 0; i < NPORT; i++) begin : g_req
            assign req[o][i] = fq_valid[i] && (cur_port[i] == PW'(o));
        end
        mesh_rr_pick #(.N(NPORT), .IW(PW)) u_arb (
            .req(req[o]),
            .ptr(st_q.ptr[o]),
            .idx(pick_idx[o]),
            .any(pick_any[o])
        );
        assign out_flit[o*FLIT_W +: FLIT_W] = fq_data[sel[o]];
    end

    assign out_valid = ov;

    always_comb begin
        logic closes;
        st_d = st_q;
        pop  = '0;
        for (int o = 0; o < NPORT; o++) begin
            sel[o]  = st_q.lock[o] ? st_q.owner[o] : pick_idx[o];
            ov[o]   = st_q.lock[o] ? fq_valid[sel[o]] : pick_any[o];
            xfer[o] = ov[o] && out_ready[o];
            closes  = fq_data[sel[o]][TL+1];
            if (!st_q.lock[o]) st_d.owner[o] = sel[o];
            st_d.lock[o] = (st_q.lock[o] || ov[o]) && !(xfer[o] && closes);
            if (xfer[o] && closes)
                st_d.ptr[o] = (sel[o] == PW'(NPORT - 1)) ? '0 : sel[o] + PW'(1);
            if (xfer[o]) pop[sel[o]] = 1'b1;
        end
        for (int i = 0; i < NPORT; i++) begin
            if (pop[i]) begin
                if (fq_data[i][TL+1:TL] == FT_HEAD) begin
                    st_d.busy[i]  = 1'b1;
                    st_d.route[i] = cur_port[i];
                end else if (fq_data[i][TL+1]) begin
                    st_d.busy[i]  = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_chk_out
        // R6: a stalled output holds its flit
        p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ov[o] && !out_ready[o] |=> ov[o] && $stable(out_flit[o*FLIT_W +: FLIT_W]));
        // R4: a held output stays with an input that still routes to it
        p_lock_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.lock[o] |-> (cur_port[st_q.owner[o]] == PW'(o)));
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_chk_in
        logic [NPORT-1:0] hit;
        always_comb begin
            for (int o = 0; o < NPORT; o++) hit[o] = ov[o] && (sel[o] == PW'(i));
        end
        // R4: one input feeds at most one output
        p_one_output_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(hit) <= 1);
    end

    // R2: head flits leaving east or west lie on that side in X
    p_xy_east_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ov[P_EAST] && out_flit[P_EAST*FLIT_W+TL] |->
        out_flit[P_EAST*FLIT_W+CW +: CW] > HX);
    p_xy_west_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ov[P_WEST] && out_flit[P_WEST*FLIT_W+TL] |->
        out_flit[P_WEST*FLIT_W+CW +: CW] < HX);
    // R3: head flits leaving local are addressed to this node
    p_xy_local_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ov[P_LOCAL] && out_flit[TL] |->
        out_flit[CW +: CW] == HX && out_flit[0 +: CW] == HY);
endmodule

// File: tb/mesh_router_tb.sv
`timescale 1ns/100ps
module mesh_router_tb;
    localparam int NP = 5;
    localparam int FW = 16;
    localparam int DEPTH = 4;
    localparam int QD = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0] in_valid, in_ready, out_valid, out_ready;
    logic [NP*FW-1:0] in_flit, out_flit;

    logic drv_val [NP];
    logic [FW-1:0] drv_flit [NP];

    logic [FW-1:0] expq [NP][NP][QD];
    int wp [NP][NP];
    int rp [NP][NP];
    int logsrc [NP][64];
    int logn [NP];
    bit in_pkt [NP];
    int cur_src [NP];
    bit stall [NP];
    logic [FW-1:0] held [NP];
    int seqc [NP];

    bit rdy_rand = 1'b0;
    logic [NP-1:0] rdy_force = '1;
    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            in_valid[i] = drv_val[i];
            in_flit[i*FW +: FW] = drv_flit[i];
        end
    end

    mesh_router #(.FLIT_W(FW), .DEPTH(DEPTH), .CW(2), .MY_X(1), .MY_Y(1)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_flit(in_flit), .in_ready(in_ready),
        .out_valid(out_valid), .out_flit(out_flit), .out_ready(out_ready)
    );

    function automatic int xy_port(int dx, int dy);
        if (dx > 1) return 3;
        if (dx < 1) return 4;
        if (dy > 1) return 1;
        if (dy < 1) return 2;
        return 0;
    endfunction

    function automatic logic [FW-1:0] mk(logic [1:0] t, int src, int seq, int dx, int dy);
        return {t, 3'(src), 7'(seq), 2'(dx), 2'(dy)};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    // called at a negedge; returns at a negedge with valid dropped
    task automatic push(int src, int o, logic [FW-1:0] f);
        drv_val[src] = 1'b1;
        drv_flit[src] = f;
        while (!in_ready[src]) @(negedge clk);
        expq[o][src][wp[o][src] % QD] = f;
        wp[o][src]++;
        @(negedge clk);
        drv_val[src] = 1'b0;
    endtask

    task automatic send_pkt(int src, int dx, int dy, int len);
        int o;
        o = xy_port(dx, dy);
        for (int f = 0; f < len; f++) begin
            logic [1:0] t;
            if (len == 1) t = 2'b11;
            else if (f == 0) t = 2'b01;
            else if (f == len - 1) t = 2'b10;
            else t = 2'b00;
            push(src, o, mk(t, src, seqc[src], (f == 0) ? dx : 0, (f == 0) ? dy : 0));
            seqc[src]++;
        end
    endtask

    task automatic consume(int o, logic [FW-1:0] f);
        int src, dx, dy;
        logic [1:0] t;
        src = int'(f[13:11]);
        t = f[15:14];
        dx = int'(f[3:2]);
        dy = int'(f[1:0]);
        if (t[0]) chk(xy_port(dx, dy) == o, (dx != 1) ? "R2" : "R3", "output port of head",
                      32'(o), 32'(xy_port(dx, dy)));
        chk(!(in_pkt[o] && (src != cur_src[o] || t[0])), "R4", "flit inside open packet",
            32'(src), 32'(cur_src[o]));
        if (t == 2'b01) begin
            in_pkt[o] = 1'b1;
            cur_src[o] = src;
        end else if (t[1]) begin
            in_pkt[o] = 1'b0;
        end
        if (src < NP && rp[o][src] != wp[o][src]) begin
            chk(expq[o][src][rp[o][src] % QD] == f, "R8", "flit contents/order",
                32'(f), 32'(expq[o][src][rp[o][src] % QD]));
            rp[o][src]++;
        end else begin
            chk(1'b0, "R8", "unexpected flit", 32'(f), 32'hffff_ffff);
        end
        if (logn[o] < 64) begin
            logsrc[o][logn[o]] = src;
            logn[o]++;
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            out_ready = '1;
            for (int o = 0; o < NP; o++) stall[o] = 1'b0;
        end else begin
            for (int o = 0; o < NP; o++)
                out_ready[o] = rdy_rand ? (($urandom % 10) < 7) : rdy_force[o];
            for (int o = 0; o < NP; o++) begin
                logic [FW-1:0] f;
                f = out_flit[o*FW +: FW];
                if (stall[o]) chk(out_valid[o] && f == held[o], "R6", "stalled output changed",
                                  32'(f), 32'(held[o]));
                stall[o] = out_valid[o] && !out_ready[o];
                held[o] = f;
                if (out_valid[o] && out_ready[o]) consume(o, f);
            end
        end
    end

    function automatic bit drained();
        for (int o = 0; o < NP; o++)
            for (int s = 0; s < NP; s++)
                if (rp[o][s] != wp[o][s]) return 1'b0;
        return 1'b1;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 0, 1);
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NP; i++) begin
            drv_val[i] = 1'b0;
            drv_flit[i] = '0;
            seqc[i] = 0;
            logn[i] = 0;
            in_pkt[i] = 1'b0;
            cur_src[i] = 0;
            for (int s = 0; s < NP; s++) begin
                wp[i][s] = 0;
                rp[i][s] = 0;
            end
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(out_valid == '0, "R1", "out_valid in reset", 32'(out_valid), 32'h0);
        chk(in_ready == '1, "R1", "in_ready in reset", 32'(in_ready), 32'h1f);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == '0, "R1", "out_valid after reset", 32'(out_valid), 32'h0);
        chk(in_ready == '1, "R1", "in_ready after reset", 32'(in_ready), 32'h1f);

        // R2 R3: every destination from the local input, then multi-flit from east
        for (int dx = 0; dx < 3; dx++)
            for (int dy = 0; dy < 3; dy++)
                send_pkt(0, dx, dy, 1);
        send_pkt(3, 0, 2, 3);
        send_pkt(3, 1, 0, 4);
        repeat (12) @(negedge clk);
        chk(drained(), "R2", "directed routes delivered", 32'(drained()), 32'h1);

        // R5: three simultaneous contenders for local, then a wrap-around pair
        for (int i = 0; i < NP; i++) logn[i] = 0;
        fork
            send_pkt(1, 1, 1, 1);
            send_pkt(2, 1, 1, 1);
            send_pkt(3, 1, 1, 1);
        join
        repeat (8) @(negedge clk);
        chk(logn[0] == 3, "R5", "local grants count", 32'(logn[0]), 32'd3);
        chk(logsrc[0][0] == 1 && logsrc[0][1] == 2 && logsrc[0][2] == 3, "R5", "grant order 1,2,3",
            32'(logsrc[0][0] * 100 + logsrc[0][1] * 10 + logsrc[0][2]), 32'd123);
        fork
            send_pkt(2, 1, 1, 1);
            send_pkt(4, 1, 1, 1);
        join
        repeat (8) @(negedge clk);
        chk(logn[0] == 5 && logsrc[0][3] == 4 && logsrc[0][4] == 2, "R5", "pointer wrap order 4,2",
            32'(logsrc[0][3] * 10 + logsrc[0][4]), 32'd42);

        // R7 R6 R4: fill input 0 behind a blocked east output
        rdy_force[3] = 1'b0;
        push(0, 3, mk(2'b01, 0, 100, 2, 1));
        for (int k = 1; k < DEPTH; k++) push(0, 3, mk(2'b00, 0, 100 + k, 0, 0));
        chk(in_ready[0] == 1'b0, "R7", "in_ready when full", 32'(in_ready[0]), 32'h0);
        chk(in_ready[1] == 1'b1, "R7", "other input still ready", 32'(in_ready[1]), 32'h1);
        push(1, 3, mk(2'b11, 1, 120, 2, 2));
        @(negedge clk);
        chk(out_valid[3] && out_flit[3*FW +: FW] == mk(2'b01, 0, 100, 2, 1), "R4",
            "east held by first packet", 32'(out_flit[3*FW +: FW]), 32'(mk(2'b01, 0, 100, 2, 1)));
        rdy_force[3] = 1'b1;
        push(0, 3, mk(2'b10, 0, 110, 0, 0));
        repeat (12) @(negedge clk);
        chk(drained(), "R7", "blocked packet delivered", 32'(drained()), 32'h1);

        // R8: random traffic on all inputs with random backpressure
        rdy_rand = 1'b1;
        fork
            for (int s = 0; s < NP; s++) begin
                automatic int src = s;
                fork
                    begin
                        for (int p = 0; p < 25; p++) begin
                            send_pkt(src, int'($urandom % 3), int'($urandom % 3), 1 + int'($urandom % 4));
                            repeat ($urandom % 3) @(negedge clk);
                        end
                    end
                join_none
            end
        join_none
        wait fork;
        rdy_rand = 1'b0;
        rdy_force = '1;
        for (int c = 0; c < 2000 && !drained(); c++) @(negedge clk);
        chk(drained(), "R8", "all random flits delivered", 32'(drained()), 32'h1);
        chk(out_valid == '0, "R8", "outputs idle after drain", 32'(out_valid), 32'h0);

        summary();
        $finish;
    end
endmodule